// File: doc/BRIEF.md
# Stream Write Receive Controller

This block is the card-side engine for an open-ended stream write over a single serial data line. A start command carries a byte address. The controller checks that the bus is one bit wide and in single data rate mode, and that the address lies inside the memory and meets the alignment rule. It then collects serial bits into bytes and hands each byte to a memory write port at an address that increases by one per byte. This continues until a stop command arrives.

A stream has no length and no CRC. While streaming, the controller watches for three faults: the end of memory being passed, a byte arriving before the previous one could be programmed, and a byte aimed at a write-protected address. Any of these halts programming and discards all later data. The controller still stays in the receive state, and the latched fault bits are reported in the response to the stop command. A one-byte holding register sits between the byte assembler and the memory port, and it absorbs the backpressure from the memory port.

Top module: `strm_wr_ctrl`

## Requirements
- R1: After reset the controller is in the transfer state (`in_rcv`=0). It issues no memory write and no response.
- R2: A start command is answered one cycle later on `rsp_valid` with `rsp_flags[0]` (illegal) set, and the controller stays in the transfer state, when `bus_1bit`=0 or `bus_ddr`=1.
- R3: A start address of `MEM_BYTES` or more is rejected. The response has `rsp_flags[1]` (out of range) set, and the controller stays in the transfer state.
- R4: When `partial_en`=0, a start address that is not a multiple of `BLK_BYTES` is rejected with `rsp_flags[4]` (misalign). A stop after a byte count that is not a multiple of `BLK_BYTES` also reports `rsp_flags[4]`. When `partial_en`=1, any start address and any stop point are accepted.
- R5: An accepted start is answered one cycle later with all flags clear, and `in_rcv` is 1 from that cycle on.
- R6: Serial bits are taken on cycles with `dat_vld`=1, most significant bit first. Each completed byte is written to the start address plus the number of bytes already accepted. No CRC is expected.
- R7: While `mem_wr_en`=1 and `mem_ready`=0, the write address and data stay unchanged until the write is taken.
- R8: A byte that arrives once the address has passed the last memory byte is discarded. All later bytes are discarded too, and the stop response carries `rsp_flags[1]`.
- R9: A byte whose target address is reported protected by `wp_hit` is not written. It and all later bytes are discarded, and the stop response carries `rsp_flags[3]`.
- R10: A byte that completes while the holding register is full and `mem_ready`=0 is an overrun. It and all later bytes are discarded, the byte already held is still programmed, and the stop response carries `rsp_flags[2]`.
- R11: After any fault the controller stays in the receive state until a stop. The stop returns it to the transfer state and clears all fault bits, so the next stream starts clean.
- R12: A stop in the transfer state, or a start in the receive state, is answered with `rsp_flags[0]` and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Decoded stream-write start command (one-cycle pulse) |
| cmd_stop | input | 1 | Decoded stop command (one-cycle pulse) |
| cmd_addr | input | ADDR_W | Start byte address carried by the start command |
| bus_1bit | input | 1 | Bus is configured one bit wide |
| bus_ddr | input | 1 | Bus is in dual data rate mode |
| partial_en | input | 1 | Arbitrary start and stop byte addresses allowed |
| dat_vld | input | 1 | Serial data bit valid this cycle |
| dat_bit | input | 1 | Serial data bit |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| wp_addr | output | ADDR_W | Address of the next byte, for the write-protect lookup |
| wp_hit | input | 1 | The address on wp_addr is protected |
| rsp_valid | output | 1 | Response to the previous cycle's command |
| rsp_flags | output | 5 | [0] illegal, [1] out of range, [2] overrun, [3] write protect, [4] misalign |
| in_rcv | output | 1 | 1 in the receive state, 0 in the transfer state |

## Verification
The bench builds the controller with `ADDR_W`=12, `MEM_BYTES`=64 and `BLK_BYTES`=8. With a 64-byte memory, a stream that starts a few bytes below the top runs past the end after only a handful of bytes. The 8-byte block makes both the misaligned start and the misaligned stop cheap to reach. A write-protect window placed at one block boundary and a memory port held not ready show the protect and overrun faults. In each of these cases the bench checks which bytes were programmed before programming halted, and checks that a clean stream follows each fault stream.

// File: rtl/strm_wr_pkg.sv
package strm_wr_pkg;
   typedef enum logic {ST_TRAN = 1'b0, ST_RCV = 1'b1} st_e;
   localparam int FLG_ILL = 0;
   localparam int FLG_OOR = 1;
   localparam int FLG_OVR = 2;
   localparam int FLG_WP  = 3;
   localparam int FLG_MIS = 4;
   localparam int FLG_W   = 5;
endpackage

// File: rtl/strm_deser.sv
module strm_deser #(
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              bit_vld,
   input  logic              bit_in,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_data
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sr;
   logic [BYTE_W-1:0] nxt;
   logic [CNT_W-1:0]  cnt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign nxt = {sr[BYTE_W-2:0], bit_in};
      end else begin : g_lsb
         assign nxt = {bit_in, sr[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr        <= '0;
         cnt       <= '0;
         byte_vld  <= 1'b0;
         byte_data <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (!active) begin
            cnt <= '0;
         end else if (bit_vld) begin
            sr <= nxt;
            if (cnt == CNT_W'(BYTE_W - 1)) begin
               cnt       <= '0;
               byte_vld  <= 1'b1;
               byte_data <= nxt;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld); // R6
endmodule

// File: rtl/strm_hold.sv
module strm_hold #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [DW-1:0] load_data,
   input  logic          mem_ready,
   output logic          full,
   output logic          mem_wr_en,
   output logic [AW-1:0] mem_wr_addr,
   output logic [DW-1:0] mem_wr_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full        <= 1'b0;
         mem_wr_addr <= '0;
         mem_wr_data <= '0;
      end else if (load) begin
         full        <= 1'b1;
         mem_wr_addr <= load_addr;
         mem_wr_data <= load_data;
      end else if (full && mem_ready) begin
         full <= 1'b0;
      end
   end

   assign mem_wr_en = full;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && !mem_ready) |=> (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!full || mem_ready)); // R10
endmodule

// File: rtl/strm_seq.sv
module strm_seq
   import strm_wr_pkg::*;
#(
   parameter int AW        = 16,
   parameter int MEM_BYTES = 32768,
   parameter int BLK_LOG   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic             cmd_stop,
   input  logic [AW-1:0]    cmd_addr,
   input  logic             bus_1bit,
   input  logic             bus_ddr,
   input  logic             partial_en,
   input  logic             byte_vld,
   input  logic             wp_hit,
   input  logic             hold_full,
   input  logic             mem_ready,
   output logic             in_rcv,
   output logic             load,
   output logic [AW-1:0]    ptr_addr,
   output logic             rsp_valid,
   output logic [FLG_W-1:0] rsp_flags
);
   localparam int PW = AW + 1;

   st_e           state;
   logic [PW-1:0] ptr;
   logic          part_q;
   logic          e_oor, e_ovr, e_wp;
   logic          halted, beyond, addr_bad;
   logic          start_mis, stop_mis;

   generate
      if (BLK_LOG == 0) begin : g_noblk
         assign start_mis = 1'b0;
         assign stop_mis  = 1'b0;
      end else begin : g_blk
         assign start_mis = |cmd_addr[BLK_LOG-1:0];
         assign stop_mis  = |ptr[BLK_LOG-1:0];
      end
   endgenerate

   assign in_rcv   = (state == ST_RCV);
   assign halted   = e_oor | e_ovr | e_wp;
   assign beyond   = (ptr >= PW'(MEM_BYTES));
   assign addr_bad = ({1'b0, cmd_addr} >= PW'(MEM_BYTES));
   assign ptr_addr = ptr[AW-1:0];
   assign load     = in_rcv && byte_vld && !cmd_start && !cmd_stop && !halted &&
                     !beyond && !wp_hit && (!hold_full || mem_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_TRAN;
         ptr       <= '0;
         part_q    <= 1'b0;
         e_oor     <= 1'b0;
         e_ovr     <= 1'b0;
         e_wp      <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_flags <= '0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_flags <= '0;
         case (state)
            ST_TRAN: begin
               if (cmd_start) begin
                  rsp_valid <= 1'b1;
                  if (!bus_1bit || bus_ddr) begin
                     rsp_flags[FLG_ILL] <= 1'b1;
                  end else if (addr_bad) begin
                     rsp_flags[FLG_OOR] <= 1'b1;
                  end else if (!partial_en && start_mis) begin
                     rsp_flags[FLG_MIS] <= 1'b1;
                  end else begin
                     state  <= ST_RCV;
                     ptr    <= {1'b0, cmd_addr};
                     part_q <= partial_en;
                     e_oor  <= 1'b0;
                     e_ovr  <= 1'b0;
                     e_wp   <= 1'b0;
                  end
               end else if (cmd_stop) begin
                  rsp_valid          <= 1'b1;
                  rsp_flags[FLG_ILL] <= 1'b1;
               end
            end
            ST_RCV: begin
               if (cmd_stop) begin
                  rsp_valid          <= 1'b1;
                  rsp_flags[FLG_OOR] <= e_oor;
                  rsp_flags[FLG_OVR] <= e_ovr;
                  rsp_flags[FLG_WP]  <= e_wp;
                  rsp_flags[FLG_MIS] <= !part_q && stop_mis;
                  state              <= ST_TRAN;
                  e_oor              <= 1'b0;
                  e_ovr              <= 1'b0;
                  e_wp               <= 1'b0;
               end else if (cmd_start) begin
                  rsp_valid          <= 1'b1;
                  rsp_flags[FLG_ILL] <= 1'b1;
               end else if (byte_vld && !halted) begin
                  if (beyond) begin
                     e_oor <= 1'b1;
                  end else if (wp_hit) begin
                     e_wp <= 1'b1;
                  end else if (hold_full && !mem_ready) begin
                     e_ovr <= 1'b1;
                  end else begin
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            default: state <= ST_TRAN;
         endcase
      end
   end

   AST_RSP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(cmd_start || cmd_stop)); // R5
   AST_ILLEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_rcv && cmd_start && (!bus_1bit || bus_ddr)) |=> (rsp_valid && rsp_flags[FLG_ILL] && !in_rcv)); // R2
   AST_STOP_TO_TRAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rcv && cmd_stop) |=> (!in_rcv && rsp_valid && !rsp_flags[FLG_ILL])); // R11
   AST_HOLD_RCV: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rcv && !cmd_stop) |=> in_rcv); // R11
endmodule

// File: rtl/strm_wr_ctrl.sv
module strm_wr_ctrl
   import strm_wr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MEM_BYTES = 32768,
   parameter int BLK_BYTES = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              bus_1bit,
   input  logic              bus_ddr,
   input  logic              partial_en,
   input  logic              dat_vld,
   input  logic              dat_bit,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [7:0]        mem_wr_data,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] wp_addr,
   input  logic              wp_hit,
   output logic              rsp_valid,
   output logic [4:0]        rsp_flags,
   output logic              in_rcv
);
   localparam int BLK_LOG = $clog2(BLK_BYTES);
   localparam int PW      = ADDR_W + 1;

   generate
      if ((1 << BLK_LOG) != BLK_BYTES) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two");
      end
      if ((MEM_BYTES % BLK_BYTES) != 0) begin : g_bad_mem
         $error("MEM_BYTES must be a whole number of blocks");
      end
      if (MEM_BYTES > (1 << ADDR_W)) begin : g_bad_aw
         $error("ADDR_W too narrow for MEM_BYTES");
      end
   endgenerate

   logic       byte_vld;
   logic [7:0] byte_data;
   logic       load;
   logic       hold_full;

   strm_deser #(.BYTE_W(8), .MSB_FIRST(1'b1)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (in_rcv),
      .bit_vld   (dat_vld),
      .bit_in    (dat_bit),
      .byte_vld  (byte_vld),
      .byte_data (byte_data)
   );

   strm_seq #(.AW(ADDR_W), .MEM_BYTES(MEM_BYTES), .BLK_LOG(BLK_LOG)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start),
      .cmd_stop   (cmd_stop),
      .cmd_addr   (cmd_addr),
      .bus_1bit   (bus_1bit),
      .bus_ddr    (bus_ddr),
      .partial_en (partial_en),
      .byte_vld   (byte_vld),
      .wp_hit     (wp_hit),
      .hold_full  (hold_full),
      .mem_ready  (mem_ready),
      .in_rcv     (in_rcv),
      .load       (load),
      .ptr_addr   (wp_addr),
      .rsp_valid  (rsp_valid),
      .rsp_flags  (rsp_flags)
   );

   strm_hold #(.AW(ADDR_W), .DW(8)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .load_addr   (wp_addr),
      .load_data   (byte_data),
      .mem_ready   (mem_ready),
      .full        (hold_full),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data)
   );

   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ({1'b0, mem_wr_addr} < PW'(MEM_BYTES))); // R8
endmodule

// File: tb/strm_wr_ctrl_bench.sv
module strm_wr_ctrl_bench;
   localparam int AW  = 12;
   localparam int MEM = 64;
   localparam int BLK = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0, cmd_stop = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic          bus_1bit = 1'b1, bus_ddr = 1'b0, partial_en = 1'b0;
   logic          dat_vld = 1'b0, dat_bit = 1'b0;
   logic          mem_wr_en;
   logic [AW-1:0] mem_wr_addr;
   logic [7:0]    mem_wr_data;
   logic          mem_ready = 1'b1;
   logic [AW-1:0] wp_addr;
   logic          wp_hit;
   logic          wp_on = 1'b0;
   logic          rsp_valid;
   logic [4:0]    rsp_flags;
   logic          in_rcv;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [AW+7:0] wq[$];
   logic [4:0]    rq[$];

   always #2.5 clk = ~clk;

   assign wp_hit = wp_on && (wp_addr >= 12'd32) && (wp_addr < 12'd40);

   strm_wr_ctrl #(.ADDR_W(AW), .MEM_BYTES(MEM), .BLK_BYTES(BLK)) u_strm_wr_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_addr(cmd_addr), .bus_1bit(bus_1bit), .bus_ddr(bus_ddr),
      .partial_en(partial_en), .dat_vld(dat_vld), .dat_bit(dat_bit),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_ready(mem_ready), .wp_addr(wp_addr), .wp_hit(wp_hit),
      .rsp_valid(rsp_valid), .rsp_flags(rsp_flags), .in_rcv(in_rcv)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares memory writes and responses against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mem_wr_en && mem_ready) begin
            if (wq.size() == 0) check(1'b0, "R6 unexpected write", {mem_wr_addr, mem_wr_data}, 0);
            else begin
               logic [AW+7:0] e;
               e = wq.pop_front();
               check({mem_wr_addr, mem_wr_data} == e, "R6 write addr/data",
                     {mem_wr_addr, mem_wr_data}, e);
            end
         end
         if (rsp_valid) begin
            if (rq.size() == 0) check(1'b0, "R12 unexpected response", rsp_flags, 0);
            else begin
               logic [4:0] f;
               f = rq.pop_front();
               check(rsp_flags == f, "R2-R12 response flags", rsp_flags, f);
            end
         end
      end
   end

   task automatic tick(); @(posedge clk); #1; endtask

   task automatic start(input logic [AW-1:0] a, input logic one, input logic ddr,
                        input logic part, input logic [4:0] exp);
      rq.push_back(exp);
      cmd_addr = a; bus_1bit = one; bus_ddr = ddr; partial_en = part; cmd_start = 1'b1;
      tick();
      cmd_start = 1'b0;
      tick();
   endtask

   task automatic stop(input logic [4:0] exp);
      rq.push_back(exp);
      cmd_stop = 1'b1;
      tick();
      cmd_stop = 1'b0;
      tick();
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         dat_vld = 1'b1; dat_bit = b[i];
         tick();
      end
      dat_vld = 1'b0;
      tick(); tick(); tick();
   endtask

   task automatic expect_wr(input int a, input logic [7:0] d);
      wq.push_back({AW'(a), d});
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) tick();
      // R1 reset state
      check(in_rcv == 1'b0, "R1 in_rcv", in_rcv, 0);
      check(mem_wr_en == 1'b0, "R1 mem_wr_en", mem_wr_en, 0);
      check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
      rst_n = 1'b1;
      tick();

      // R2 illegal bus modes
      start(12'd0, 1'b0, 1'b0, 1'b0, 5'b00001);
      check(in_rcv == 1'b0, "R2 four-bit stays idle", in_rcv, 0);
      start(12'd0, 1'b1, 1'b1, 1'b0, 5'b00001);
      check(in_rcv == 1'b0, "R2 ddr stays idle", in_rcv, 0);
      // R3 out of range start
      start(12'd64, 1'b1, 1'b0, 1'b1, 5'b00010);
      check(in_rcv == 1'b0, "R3 stays idle", in_rcv, 0);
      // R4 misaligned start
      start(12'd3, 1'b1, 1'b0, 1'b0, 5'b10000);
      check(in_rcv == 1'b0, "R4 misaligned start idle", in_rcv, 0);
      // R12 stop in transfer state
      stop(5'b00001);
      check(in_rcv == 1'b0, "R12 stop idle", in_rcv, 0);

      // R5 R6 clean aligned block
      start(12'd8, 1'b1, 1'b0, 1'b0, 5'b00000);
      check(in_rcv == 1'b1, "R5 enters receive", in_rcv, 1);
      for (int i = 0; i < 8; i++) begin
         expect_wr(8 + i, 8'hA0 + 8'(i * 7));
         send_byte(8'hA0 + 8'(i * 7));
      end
      // R12 start during receive
      start(12'd0, 1'b1, 1'b0, 1'b0, 5'b00001);
      check(in_rcv == 1'b1, "R12 start in receive keeps state", in_rcv, 1);
      stop(5'b00000);
      check(in_rcv == 1'b0, "R11 stop returns to transfer", in_rcv, 0);

      // R4 partial enabled, odd start and stop
      start(12'd5, 1'b1, 1'b0, 1'b1, 5'b00000);
      expect_wr(5, 8'h81); send_byte(8'h81);
      expect_wr(6, 8'h3C); send_byte(8'h3C);
      expect_wr(7, 8'h01); send_byte(8'h01);
      stop(5'b00000);

      // R4 misaligned stop with partial disabled
      start(12'd16, 1'b1, 1'b0, 1'b0, 5'b00000);
      expect_wr(16, 8'h11); send_byte(8'h11);
      expect_wr(17, 8'h22); send_byte(8'h22);
      expect_wr(18, 8'h33); send_byte(8'h33);
      stop(5'b10000);

      // R8 end of memory
      start(12'd60, 1'b1, 1'b0, 1'b1, 5'b00000);
      for (int i = 0; i < 6; i++) begin
         if (i < 4) expect_wr(60 + i, 8'hC0 + 8'(i));
         send_byte(8'hC0 + 8'(i));
      end
      check(in_rcv == 1'b1, "R11 stays receive after end of range", in_rcv, 1);
      stop(5'b00010);

      // R9 write protect window 32..39
      wp_on = 1'b1;
      start(12'd28, 1'b1, 1'b0, 1'b1, 5'b00000);
      for (int i = 0; i < 6; i++) begin
         if (i < 4) expect_wr(28 + i, 8'h50 + 8'(i));
         send_byte(8'h50 + 8'(i));
      end
      check(in_rcv == 1'b1, "R11 stays receive after protect", in_rcv, 1);
      stop(5'b01000);
      wp_on = 1'b0;

      // R10 overrun with memory stalled
      mem_ready = 1'b0;
      start(12'd0, 1'b1, 1'b0, 1'b1, 5'b00000);
      send_byte(8'hE7);
      check(mem_wr_en == 1'b1, "R7 write pending while stalled", mem_wr_en, 1);
      send_byte(8'h18);
      send_byte(8'h99);
      check(in_rcv == 1'b1, "R11 stays receive after overrun", in_rcv, 1);
      check(mem_wr_data == 8'hE7, "R7 held byte unchanged", mem_wr_data, 8'hE7);
      stop(5'b00100);
      expect_wr(0, 8'hE7);
      mem_ready = 1'b1;
      tick(); tick();

      // R11 flags cleared: clean stream after faults
      start(12'd40, 1'b1, 1'b0, 1'b0, 5'b00000);
      for (int i = 0; i < 8; i++) begin
         expect_wr(40 + i, 8'h0F ^ 8'(i));
         send_byte(8'h0F ^ 8'(i));
      end
      stop(5'b00000);

      repeat (5) tick();
      check(wq.size() == 0, "R6 all writes seen", wq.size(), 0);
      check(rq.size() == 0, "R12 all responses seen", rq.size(), 0);
      finish_run();
   end
endmodule